// File: doc/BRIEF.md
# Eight-Bit Waveform Timer with Mode-Dependent Compare Buffering

This block is an 8-bit counter that a prescaler paces through a one-cycle count-enable input. A 3-bit mode code selects the waveform. The counter can count up with a fixed ceiling. It can count up and clear at a ceiling taken from compare channel A. It can also run as a single-slope PWM ramp or as a dual-slope (phase-correct) triangle. Two compare channels, A and B, produce one-cycle match strobes. The block also reports the count, the slope direction, ceiling and floor strobes, and an overflow strobe. The point where the overflow strobe fires depends on the mode.

Each compare channel holds a shadow copy and an active copy. Only the active copy takes part in matching. In the non-PWM modes a write reaches both copies together. In the PWM modes a write goes only to the shadow copy, and the active copy is reloaded at the update point of that mode. As a result, the duty cycle never changes in the middle of a PWM period.

Top module: `pwm_timer8`

## Requirements
- R1: While reset is asserted and after it is released, the count is 0, the slope output is 0 (up), and both active compare values are 0. A 0 compare value therefore matches the reset count on the first enabled cycle.
- R2: The count changes only on rising clock edges where `tick` is 1. With `tick` at 0 the count holds and every strobe output is 0.
- R3: Mode codes 0, 4 and 6 (plain count) step the count 0,1,…,255,0. `ovf_stb` is 1 on each enabled cycle with count 255.
- R4: Mode code 2 (clear on match) uses active compare A as the ceiling. The count goes to 0 on the edge after an enabled cycle at the ceiling. `ovf_stb` fires only on an enabled cycle with count 255.
- R5: Mode codes 3 (ceiling 255) and 7 (ceiling = active A) are single-slope PWM. The count wraps to 0 after the ceiling, and `ovf_stb` fires together with `top_stb`.
- R6: Mode codes 1 (ceiling 255) and 5 (ceiling = active A) are dual-slope PWM. The count runs 0 up to the ceiling and back down to 0, and neither end value repeats. `count_down` is 1 while the count falls. `ovf_stb` fires together with `bottom_stb`.
- R7: `top_stb` is 1 on an enabled cycle whose count equals the current ceiling. `bottom_stb` is 1 on an enabled cycle whose count is 0.
- R8: `match_a` and `match_b` are 1 on an enabled cycle whose count equals the active compare value of that channel.
- R9: In mode codes 0, 2, 4 and 6 a write (`wr_a`/`wr_b` high for one cycle) sets the active compare value from the next edge on. In mode 2 this can move the ceiling within the current cycle of counting.
- R10: In mode codes 1, 3, 5 and 7 a write changes only the shadow copy. The active copy takes the shadow value at the end of an enabled cycle at the ceiling (dual-slope) or at count 0 (single-slope).
- R11: The slope output returns to 0 on the edge after any cycle in which a single-slope mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Count enable from the prescaler |
| mode | input | 3 | Waveform mode code |
| wr_a | input | 1 | Write strobe for compare channel A |
| wdata_a | input | 8 | Write data for compare channel A |
| wr_b | input | 1 | Write strobe for compare channel B |
| wdata_b | input | 8 | Write data for compare channel B |
| count | output | 8 | Current count value |
| count_down | output | 1 | 1 while the dual-slope count is falling |
| top_stb | output | 1 | Enabled cycle at the ceiling |
| bottom_stb | output | 1 | Enabled cycle at count 0 |
| match_a | output | 1 | Enabled cycle at active compare A |
| match_b | output | 1 | Enabled cycle at active compare B |
| ovf_stb | output | 1 | Overflow event, position set by the mode |

## Verification
All strobes are combinational from the registered count and the active compares, gated by `tick`. They are therefore due in the same cycle that presents the count, and they are sampled 1 ns after the falling edge once the inputs have settled. The count and the slope change on the first rising edge after an enabled cycle. A write reaches the active compare one edge later in immediate modes, and only after the next update point in buffered modes. The checks therefore read the count one step after the driving cycle, and they probe buffered compares on both sides of the ceiling or floor reload. After reset is released, the two-stage reset synchronizer holds the state for two more edges, so the bench waits three idle cycles before it starts counting.

// File: rtl/timer8_pkg.sv
package timer8_pkg;

  typedef enum logic [1:0] {
    OVF_AT_MAX    = 2'd0,
    OVF_AT_TOP    = 2'd1,
    OVF_AT_BOTTOM = 2'd2
  } ovf_sel_e;

  typedef struct packed {
    logic     top_from_a;
    logic     dual_slope;
    logic     buffered;
    logic     load_at_top;
    ovf_sel_e ovf_sel;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [2:0] code);
    mode_cfg_t c;
    c.top_from_a  = 1'b0;
    c.dual_slope  = 1'b0;
    c.buffered    = 1'b0;
    c.load_at_top = 1'b0;
    c.ovf_sel     = OVF_AT_MAX;
    case (code)
      3'd1, 3'd5: begin
        c.dual_slope  = 1'b1;
        c.buffered    = 1'b1;
        c.load_at_top = 1'b1;
        c.ovf_sel     = OVF_AT_BOTTOM;
        c.top_from_a  = code[2];
      end
      3'd2: begin
        c.top_from_a = 1'b1;
      end
      3'd3, 3'd7: begin
        c.buffered   = 1'b1;
        c.ovf_sel    = OVF_AT_TOP;
        c.top_from_a = code[2];
      end
      default: begin
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/timer8_mode_decode.sv
module timer8_mode_decode
  import timer8_pkg::*;
(
  input  logic [2:0] mode,
  output mode_cfg_t  cfg
);

  always_comb begin
    cfg = decode_mode(mode);
  end

endmodule

// File: rtl/timer8_counter.sv
module timer8_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             dual_slope,
  input  logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_down,
  output logic             at_top,
  output logic             at_bottom
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dual_slope ? dir_q : 1'b0;
    if (tick) begin
      if (!dual_slope) begin
        cnt_d = (cnt_q == top_val) ? ZERO : cnt_q + ONE;
      end else if (!dir_q) begin
        if (cnt_q == top_val) begin
          if (top_val == ZERO) begin
            cnt_d = ZERO;
          end else begin
            cnt_d = cnt_q - ONE;
            dir_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q == ZERO) begin
          cnt_d = ONE;
          dir_d = 1'b0;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt       = cnt_q;
  assign dir_down  = dir_q;
  assign at_top    = tick && (cnt_q == top_val);
  assign at_bottom = tick && (cnt_q == ZERO);

endmodule

// File: rtl/timer8_cmp_chan.sv
module timer8_cmp_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             buffered,
  input  logic             load_now,
  output logic [CNT_W-1:0] active
);

  logic [CNT_W-1:0] shadow_q, shadow_d;
  logic [CNT_W-1:0] active_q, active_d;

  always_comb begin
    shadow_d = wr ? wdata : shadow_q;
    active_d = active_q;
    if (!buffered) begin
      if (wr) active_d = wdata;
    end else if (load_now) begin
      active_d = shadow_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
    end
  end

  assign active = active_q;

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import timer8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [2:0]       mode,
  input  logic             wr_a,
  input  logic [CNT_W-1:0] wdata_a,
  input  logic             wr_b,
  input  logic [CNT_W-1:0] wdata_b,
  output logic [CNT_W-1:0] count,
  output logic             count_down,
  output logic             top_stb,
  output logic             bottom_stb,
  output logic             match_a,
  output logic             match_b,
  output logic             ovf_stb
);

  localparam int               N_CH    = 2;
  localparam int               SYNC_N  = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_N-1:0] rst_pipe_q;
  logic              rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_N-1];

  mode_cfg_t        cfg;
  logic [CNT_W-1:0] top_val;
  logic             at_top, at_bottom, load_now;
  logic [CNT_W-1:0] cnt;
  logic             wr_ch    [N_CH];
  logic [CNT_W-1:0] wdata_ch [N_CH];
  logic [CNT_W-1:0] active_ch[N_CH];
  logic             match_ch [N_CH];

  timer8_mode_decode u_decode (
    .mode (mode),
    .cfg  (cfg)
  );

  assign top_val  = cfg.top_from_a ? active_ch[0] : CNT_MAX;
  assign load_now = cfg.buffered && (cfg.load_at_top ? at_top : at_bottom);

  timer8_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick       (tick),
    .dual_slope (cfg.dual_slope),
    .top_val    (top_val),
    .cnt        (cnt),
    .dir_down   (count_down),
    .at_top     (at_top),
    .at_bottom  (at_bottom)
  );

  assign wr_ch[0]    = wr_a;
  assign wr_ch[1]    = wr_b;
  assign wdata_ch[0] = wdata_a;
  assign wdata_ch[1] = wdata_b;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    timer8_cmp_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr       (wr_ch[ch]),
      .wdata    (wdata_ch[ch]),
      .buffered (cfg.buffered),
      .load_now (load_now),
      .active   (active_ch[ch])
    );
    assign match_ch[ch] = tick && (cnt == active_ch[ch]);
  end

  always_comb begin
    case (cfg.ovf_sel)
      OVF_AT_TOP:    ovf_stb = at_top;
      OVF_AT_BOTTOM: ovf_stb = at_bottom;
      default:       ovf_stb = tick && (cnt == CNT_MAX);
    endcase
  end

  assign count      = cnt;
  assign top_stb    = at_top;
  assign bottom_stb = at_bottom;
  assign match_a    = match_ch[0];
  assign match_b    = match_ch[1];

endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             tick,
  input logic [2:0]       mode,
  input logic [CNT_W-1:0] count,
  input logic             count_down,
  input logic             top_stb,
  input logic             bottom_stb,
  input logic             match_a,
  input logic             match_b,
  input logic             ovf_stb
);

  logic dual_m, fast_m;
  assign dual_m = (mode == 3'd1) || (mode == 3'd5);
  assign fast_m = (mode == 3'd3) || (mode == 3'd7);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    !tick |=> count == $past(count));

  p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (tick && !dual_m && !top_stb) |=> count == CNT_W'($past(count) + 1));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (tick && !dual_m && top_stb) |=> count == '0);

  p_rise_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (tick && dual_m && !count_down && !top_stb) |=> count == CNT_W'($past(count) + 1));

  p_fall_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (tick && dual_m && count_down && !bottom_stb) |=> count == CNT_W'($past(count) - 1));

  p_ovf_dual_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (dual_m && ovf_stb) |-> bottom_stb);

  p_ovf_fast_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (fast_m && ovf_stb) |-> top_stb);

  p_bottom_zero_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    bottom_stb |-> count == '0);

  p_strobe_gated_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (top_stb || bottom_stb || match_a || match_b || ovf_stb) |-> tick);

  p_slope_flat_r11: assert property (@(posedge clk) disable iff (!rst_ok)
    !dual_m |=> !count_down);

endmodule

bind pwm_timer8 pwm_timer8_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .tick       (tick),
  .mode       (mode),
  .count      (count),
  .count_down (count_down),
  .top_stb    (top_stb),
  .bottom_stb (bottom_stb),
  .match_a    (match_a),
  .match_b    (match_b),
  .ovf_stb    (ovf_stb)
);

// File: tb/pwm_timer8_tb.sv
`timescale 1ns/100ps
module pwm_timer8_tb;

  logic       clk = 1'b0;
  logic       rst_n, tick, wr_a, wr_b;
  logic [2:0] mode;
  logic [7:0] wdata_a, wdata_b;
  logic [7:0] count;
  logic       count_down, top_stb, bottom_stb, match_a, match_b, ovf_stb;

  int nvec  = 0;
  int nfail = 0;

  pwm_timer8 u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode),
    .wr_a(wr_a), .wdata_a(wdata_a), .wr_b(wr_b), .wdata_b(wdata_b),
    .count(count), .count_down(count_down), .top_stb(top_stb),
    .bottom_stb(bottom_stb), .match_a(match_a), .match_b(match_b),
    .ovf_stb(ovf_stb)
  );

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [2:0]  m;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [15:0] n;
    logic [7:0]  fin;
    logic [7:0]  ntop;
    logic [7:0]  nbot;
    logic [7:0]  novf;
    logic [7:0]  nma;
    logic [7:0]  nmb;
  } vec_t;

  // mode, A, B, enabled cycles, final count, top, bottom, ovf, match A, match B
  localparam vec_t VECS [7] = '{
    '{3'd0, 8'd10,  8'd200, 16'd300, 8'd44, 8'd1, 8'd2, 8'd1, 8'd2, 8'd1},
    '{3'd2, 8'd9,   8'd4,   16'd25,  8'd5,  8'd2, 8'd3, 8'd0, 8'd2, 8'd3},
    '{3'd3, 8'd100, 8'd0,   16'd256, 8'd0,  8'd1, 8'd1, 8'd1, 8'd1, 8'd1},
    '{3'd1, 8'd5,   8'd255, 16'd520, 8'd10, 8'd1, 8'd2, 8'd2, 8'd3, 8'd1},
    '{3'd7, 8'd6,   8'd2,   16'd20,  8'd6,  8'd2, 8'd3, 8'd2, 8'd2, 8'd3},
    '{3'd5, 8'd4,   8'd1,   16'd17,  8'd1,  8'd2, 8'd3, 8'd3, 8'd2, 8'd4},
    '{3'd4, 8'd3,   8'd250, 16'd260, 8'd4,  8'd1, 8'd2, 8'd1, 8'd2, 8'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic t);
    @(negedge clk);
    tick = t;
    wr_a = 1'b0;
    wr_b = 1'b0;
    #1;
  endtask

  task automatic write_ab(input logic da, input logic [7:0] va,
                          input logic db, input logic [7:0] vb,
                          input logic [2:0] m);
    @(negedge clk);
    tick    = 1'b0;
    mode    = m;
    wr_a    = da;
    wdata_a = va;
    wr_b    = db;
    wdata_b = vb;
    #1;
  endtask

  task automatic run_until(input logic [7:0] v, input logic d, input string req);
    bit hit = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      step(1'b1);
      if (count == v && count_down == d) begin
        hit = 1'b1;
        break;
      end
    end
    if (!hit) chk(req, int'(count), int'(v));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick = 1'b0; wr_a = 1'b0; wr_b = 1'b0; mode = 3'd0;
    wdata_a = '0; wdata_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int ntop, nbot, novf, nma, nmb;
    rst_n = 1'b0; tick = 1'b0; wr_a = 1'b0; wr_b = 1'b0; mode = 3'd0;
    wdata_a = '0; wdata_b = '0;

    // R1: state during and after reset
    @(negedge clk); tick = 1'b1; #1;
    chk("R1 count in reset", int'(count), 0);
    chk("R1 slope in reset", int'(count_down), 0);
    do_reset();
    step(1'b1);
    chk("R1 count after reset", int'(count), 0);
    chk("R1 compare A reset to 0", int'(match_a), 1);
    chk("R1 compare B reset to 0", int'(match_b), 1);

    // Vector table: R3 R4 R5 R6 R7 R8
    foreach (VECS[i]) begin
      do_reset();
      write_ab(1'b1, VECS[i].a, 1'b1, VECS[i].b, 3'd0);
      step(1'b0);
      mode = VECS[i].m;
      ntop = 0; nbot = 0; novf = 0; nma = 0; nmb = 0;
      for (int k = 0; k < int'(VECS[i].n); k++) begin
        step(1'b1);
        ntop += int'(top_stb);
        nbot += int'(bottom_stb);
        novf += int'(ovf_stb);
        nma  += int'(match_a);
        nmb  += int'(match_b);
      end
      step(1'b0);
      chk($sformatf("R3/R4/R5/R6 final count row %0d", i), int'(count), int'(VECS[i].fin));
      chk($sformatf("R7 top strobes row %0d", i), ntop, int'(VECS[i].ntop));
      chk($sformatf("R7 bottom strobes row %0d", i), nbot, int'(VECS[i].nbot));
      chk($sformatf("R3/R5/R6 overflow strobes row %0d", i), novf, int'(VECS[i].novf));
      chk($sformatf("R8 match A row %0d", i), nma, int'(VECS[i].nma));
      chk($sformatf("R8 match B row %0d", i), nmb, int'(VECS[i].nmb));
    end

    // R2: no advance and no strobes without tick
    do_reset();
    repeat (3) step(1'b1);
    repeat (5) step(1'b0);
    chk("R2 count holds", int'(count), 3);
    chk("R2 strobes quiet", int'(top_stb | bottom_stb | match_a | match_b | ovf_stb), 0);

    // R9: immediate compare write moves the clear-on-match ceiling
    do_reset();
    write_ab(1'b1, 8'd9, 1'b0, 8'd0, 3'd2);
    step(1'b0);
    run_until(8'd3, 1'b0, "R9 reach 3");
    write_ab(1'b1, 8'd5, 1'b0, 8'd0, 3'd2);
    run_until(8'd5, 1'b0, "R9 reach 5");
    chk("R9 new ceiling strobe", int'(top_stb), 1);
    step(1'b0);
    chk("R4 R9 wrap at new ceiling", int'(count), 0);

    // R10: dual-slope reload at the ceiling
    do_reset();
    write_ab(1'b1, 8'd5, 1'b0, 8'd0, 3'd0);
    step(1'b0);
    mode = 3'd1;
    run_until(8'd3, 1'b0, "R10 reach 3 up");
    write_ab(1'b1, 8'd7, 1'b0, 8'd0, 3'd1);
    run_until(8'd5, 1'b0, "R10 reach 5 up");
    chk("R10 old compare kept before ceiling", int'(match_a), 1);
    run_until(8'd7, 1'b0, "R10 reach 7 up");
    chk("R10 new compare not yet active", int'(match_a), 0);
    run_until(8'd7, 1'b1, "R10 reach 7 down");
    chk("R10 new compare after ceiling", int'(match_a), 1);
    chk("R6 slope falling", int'(count_down), 1);
    run_until(8'd5, 1'b1, "R10 reach 5 down");
    chk("R10 old compare retired", int'(match_a), 0);
    mode = 3'd3;
    step(1'b0);
    chk("R11 slope cleared in single-slope mode", int'(count_down), 0);

    // R10: single-slope reload at count 0
    do_reset();
    write_ab(1'b1, 8'd100, 1'b0, 8'd0, 3'd0);
    step(1'b0);
    mode = 3'd3;
    run_until(8'd20, 1'b0, "R10 reach 20");
    write_ab(1'b1, 8'd30, 1'b0, 8'd0, 3'd3);
    run_until(8'd30, 1'b0, "R10 reach 30");
    chk("R10 shadow write not active mid-period", int'(match_a), 0);
    run_until(8'd100, 1'b0, "R10 reach 100");
    chk("R10 old compare still active", int'(match_a), 1);
    step(1'b1);
    run_until(8'd0, 1'b0, "R10 reach 0");
    run_until(8'd30, 1'b0, "R10 reach 30 again");
    chk("R10 compare loaded at bottom", int'(match_a), 1);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule